// File: doc/BRIEF.md
# Configurable-Frame Serial Transmitter

This block turns one byte at a time into an asynchronous serial frame on a single output line. A producer offers a byte with a valid/ready handshake. On the cycle the byte is taken, the block also captures the bit-period divisor and the frame format: the number of data bits, the parity mode and the stop length. The line then carries a low start bit, the data bits least significant first, an optional parity bit and a high stop period. Changes on the inputs during a frame have no effect on that frame.

Timing is set by an integer divisor counted in clock cycles. Each bit period is split into two halves, so a one-and-a-half bit stop period comes out exact even for odd divisors. A sticky completion flag rises only when the stop period has fully left the line. Software may poll this flag after loading a byte. Loading the next byte clears it.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd` is 1, `in_ready` is 1, `busy` is 0, and `done` keeps its value; `done` is 0 after reset.
- R2: A byte is accepted on a rising clock edge where `in_valid` and `in_ready` are both 1. Starting in the next cycle, `txd` is 0 for one bit period (the start bit).
- R3: `len_sel` selects the data length: 0 gives 5 bits, 1 gives 7 bits, and 2 or 3 give 8 bits. Data bits follow the start bit with bit 0 first. Bits of `in_data` above the selected length are never sent.
- R4: `par_mode` selects parity: 0 none, 1 even, 2 odd, 3 mark (always 1), 4 space (always 0), and 5 to 7 none. Parity covers only the sent data bits. When enabled, the parity bit takes the bit period directly after the last data bit. For example, data 011 gives 0 with even parity and 1 with odd parity.
- R5: `stop_sel` selects the high stop period: 0 gives one bit period, 1 gives div + floor(div/2) cycles, and 2 or 3 give two bit periods.
- R6: Each start, data and parity bit lasts exactly `divisor` cycles, where `divisor` is at least 2.
- R7: From the cycle after acceptance until the stop period ends, `in_ready` is 0 and `busy` is 1. `in_valid` asserted in that window is ignored, and the byte is neither taken nor sent.
- R8: `done` becomes 1 in the first cycle after the stop period, together with `in_ready`. It stays 1 until the next acceptance, which clears it in the following cycle.
- R9: `in_data`, `divisor`, `len_sel`, `par_mode` and `stop_sel` are captured at acceptance. Changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Block can take a byte |
| divisor | input | DIV_W | Clock cycles per bit period (at least 2) |
| len_sel | input | 2 | Data length select |
| par_mode | input | 3 | Parity mode select |
| stop_sel | input | 2 | Stop length select |
| txd | output | 1 | Serial output line |
| busy | output | 1 | Frame in progress |
| done | output | 1 | Sticky completion flag |

## Verification
The bench builds the block with the default `DIV_W` of 16 and drives run-time divisors of 4, 5, 7 and 625. The large divisor is the 115200-baud setting at 72 MHz.

The odd divisors give unequal half periods, which is the only way to expose an error in the one-and-a-half stop length. The small divisors keep every combination of length, parity and stop short enough to compare `txd`, `busy` and `done` against a computed waveform on every cycle of every frame. That same comparison also covers back-to-back frames and frames during which the inputs are disturbed.

// File: rtl/uart_frame_tx.sv
`timescale 1ns/1ps
module uart_frame_tx #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DIV_W-1:0] divisor,
  input  logic [1:0]       len_sel,
  input  logic [2:0]       par_mode,
  input  logic [1:0]       stop_sel,
  output logic             txd,
  output logic             busy,
  output logic             done
);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t              st;
  logic [7:0]       sh;
  logic [DIV_W-1:0] div_q, cnt;
  logic [2:0]       hidx, bcnt, nlast, stop_m1;
  logic             par_bit, par_on;

  logic [7:0]       mask, pdat;
  logic [DIV_W-1:0] lo_half, hi_half, half_len;
  logic             accept, half_end, last_half;
  logic [2:0]       halves_m1;

  assign accept    = in_valid && in_ready;
  assign mask      = (len_sel == 2'd0) ? 8'h1F : (len_sel == 2'd1) ? 8'h7F : 8'hFF;
  assign pdat      = in_data & mask;
  assign lo_half   = div_q >> 1;
  assign hi_half   = div_q - lo_half;
  assign half_len  = hidx[0] ? hi_half : lo_half;
  assign half_end  = (cnt == half_len - 1'b1);
  assign halves_m1 = (st == S_STOP) ? stop_m1 : 3'd1;
  assign last_half = half_end && (hidx == halves_m1);

  assign in_ready  = (st == S_IDLE);
  assign busy      = !in_ready;

  always_comb begin
    case (st)
      S_START: txd = 1'b0;
      S_DATA:  txd = sh[0];
      S_PAR:   txd = par_bit;
      default: txd = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      sh      <= '0;
      div_q   <= '0;
      cnt     <= '0;
      hidx    <= '0;
      bcnt    <= '0;
      nlast   <= '0;
      stop_m1 <= '0;
      par_bit <= 1'b0;
      par_on  <= 1'b0;
      done    <= 1'b0;
    end else if (accept) begin
      st      <= S_START;
      sh      <= pdat;
      div_q   <= divisor;
      cnt     <= '0;
      hidx    <= '0;
      bcnt    <= '0;
      done    <= 1'b0;
      nlast   <= (len_sel == 2'd0) ? 3'd4 : (len_sel == 2'd1) ? 3'd6 : 3'd7;
      stop_m1 <= (stop_sel == 2'd0) ? 3'd1 : (stop_sel == 2'd1) ? 3'd2 : 3'd3;
      par_on  <= (par_mode >= 3'd1) && (par_mode <= 3'd4);
      case (par_mode)
        3'd1:    par_bit <= ^pdat;
        3'd2:    par_bit <= ~^pdat;
        3'd3:    par_bit <= 1'b1;
        default: par_bit <= 1'b0;
      endcase
    end else if (st != S_IDLE) begin
      if (half_end) begin
        cnt  <= '0;
        hidx <= last_half ? 3'd0 : hidx + 3'd1;
      end else begin
        cnt <= cnt + 1'b1;
      end
      if (last_half) begin
        case (st)
          S_START: st <= S_DATA;
          S_DATA: begin
            sh   <= sh >> 1;
            bcnt <= bcnt + 3'd1;
            if (bcnt == nlast) st <= par_on ? S_PAR : S_STOP;
          end
          S_PAR: st <= S_STOP;
          default: begin
            st   <= S_IDLE;
            done <= 1'b1;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/uart_frame_tx_chk.sv
`timescale 1ns/1ps
module uart_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic txd,
  input logic busy,
  input logic done
);

  // R1
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  // R7
  ready_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);

  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!txd && busy));

  // R8
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !done);

  // R8
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($fell(busy) && in_ready && txd));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

bind uart_frame_tx uart_frame_tx_chk i_chk (.*);

// File: tb/test_uart_frame_tx.sv
`timescale 1ns/1ps
module test_uart_frame_tx;

  localparam int DIV_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [7:0]       in_data = '0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [DIV_W-1:0] divisor = 16'd4;
  logic [1:0]       len_sel = '0;
  logic [2:0]       par_mode = '0;
  logic [1:0]       stop_sel = '0;
  logic             txd, busy, done;

  int vectors = 0;
  int errors  = 0;

  uart_frame_tx #(.DIV_W(DIV_W)) i_uart_frame_tx (.*);

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Caller stands at a negedge with the block idle.
  // junk: hold in_valid with other data and format through the frame (R7, R9).
  task automatic send(input logic [7:0] d, input logic [1:0] ln, input logic [2:0] pm,
                      input logic [1:0] sp, input int dv, input bit junk);
    int n, pon, pbit, stopc, tot;
    logic [7:0] dm;
    n    = (ln == 2'd0) ? 5 : (ln == 2'd1) ? 7 : 8;
    dm   = d & 8'((1 << n) - 1);
    pon  = (pm >= 3'd1 && pm <= 3'd4) ? 1 : 0;
    pbit = (pm == 3'd1) ? int'(^dm) : (pm == 3'd2) ? int'(~^dm) : (pm == 3'd3) ? 1 : 0;
    stopc = (sp == 2'd0) ? dv : (sp == 2'd1) ? dv + dv / 2 : 2 * dv;
    tot  = (1 + n + pon) * dv + stopc;
    chk(in_ready == 1'b1, "R7 ready before load", int'(in_ready), 1);
    in_data = d; len_sel = ln; par_mode = pm; stop_sel = sp;
    divisor = DIV_W'(dv); in_valid = 1'b1;
    @(posedge clk);
    #1;
    in_valid = junk;
    in_data = ~d; len_sel = ~ln; par_mode = pm ^ 3'd3; stop_sel = ~sp;
    divisor = DIV_W'(dv + 3);
    for (int t = 0; t <= tot; t++) begin
      int b, e;
      string tag;
      @(negedge clk);
      if (t == tot) begin
        chk(txd == 1'b1, "R5 line high after stop", int'(txd), 1);
        chk(busy == 1'b0, "R7 busy low after stop", int'(busy), 0);
        chk(done == 1'b1, "R8 done after stop", int'(done), 1);
        chk(in_ready == 1'b1, "R8 ready with done", int'(in_ready), 1);
      end else begin
        b = t / dv;
        if (b == 0) begin e = 0; tag = "R2 start bit"; end
        else if (b <= n) begin e = int'(dm[b-1]); tag = "R3 data bit"; end
        else if (pon == 1 && b == n + 1) begin e = pbit; tag = "R4 parity bit"; end
        else begin e = 1; tag = "R5 stop period"; end
        chk(int'(txd) == e, tag, int'(txd), e);
        chk(busy == 1'b1 && in_ready == 1'b0, "R7 busy during frame", int'(busy), 1);
        chk(done == 1'b0, "R8 done cleared by load", int'(done), 0);
        if (t == tot - 1) in_valid = 1'b0;
      end
    end
  endtask

  task automatic t_reset;
    chk(txd == 1'b1, "R1 reset txd", int'(txd), 1);
    chk(in_ready == 1'b1, "R1 reset ready", int'(in_ready), 1);
    chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);
    chk(done == 1'b0, "R1 reset done", int'(done), 0);
  endtask

  task automatic t_formats;
    logic [7:0] pats [4] = '{8'h03, 8'hA5, 8'hFF, 8'h6E};
    for (int l = 0; l < 4; l++)
      for (int p = 0; p < 8; p++)
        for (int s = 0; s < 3; s++)
          send(pats[(l + p + s) % 4], 2'(l), 3'(p), 2'(s), (s == 1) ? 7 : 4 + (p % 2), 1'b0);
  endtask

  task automatic t_parity_example;
    // R4: data 011 in 5 bits, even then odd
    send(8'h03, 2'd0, 3'd1, 2'd0, 4, 1'b0);
    send(8'h03, 2'd0, 3'd2, 2'd0, 4, 1'b0);
  endtask

  task automatic t_disturbed;
    // R7 R9: valid and format held with other values mid-frame
    send(8'h5A, 2'd2, 3'd1, 2'd1, 5, 1'b1);
    send(8'hC3, 2'd1, 3'd3, 2'd2, 7, 1'b1);
  endtask

  task automatic t_idle_hold;
    // R1 R8: idle with no valid keeps line high and done set
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(txd == 1'b1 && busy == 1'b0, "R1 idle line", int'(txd), 1);
      chk(done == 1'b1, "R8 done holds", int'(done), 1);
    end
  endtask

  task automatic t_baud;
    // R6: 115200 baud divisor at 72 MHz
    send(8'h48, 2'd2, 3'd0, 2'd0, 625, 1'b0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_parity_example();
    t_formats();
    t_disturbed();
    t_idle_hold();
    t_baud();
    t_idle_hold();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule